// File: doc/BRIEF.md
# Parallel-RGB to Low-Voltage Differential Lane Serializer

This block takes one pixel per pixel period: 8-bit red, green and blue, plus horizontal sync, vertical sync and data enable. It turns each pixel into 7-slot serial words on four data lanes and one clock lane. The block runs on a fast clock. A serial tick enable, `ser_en_i`, marks each slot, at seven ticks per pixel. Each output carries one bit per lane per slot. Differential buffers and the PLL that makes the fast clock sit outside the block.

A 2-bit mapping input selects where the colour and control bits go across the lanes. One mapping is 18-bit on three lanes. The other two are 24-bit on four lanes, one grouping the top six bits of each colour on the first three lanes and the other grouping the low six bits there. A mirror input reverses the slot order on every data lane. The block samples the pixel, the mapping and the mirror together on the tick that closes a pixel period and signals that moment on `pix_take_o`. The upstream pixel source presents its next pixel at that point.

Top module: `rgb_lane_ser`

## Requirements
- R1: A slot counter steps 0..6 on each cycle where `ser_en_i` is high and wraps from 6 to 0. `pix_take_o` is high exactly when `ser_en_i` is high and the counter is at 6. On that edge the pixel, mode and mirror inputs are loaded.
- R2: After a load, the lanes present slot 0 first, then slot 1 through slot 6, one slot per tick.
- R3: Mode 0 (18-bit) maps the colour using r6=red[7:2], g6=green[7:2] and b6=blue[7:2]. Data lane 3 stays 0 and red/green/blue bits [1:0] have no effect on any output.
- R4: For slots 0..6 the common lanes carry: lane 0 = g6[0], r6[5], r6[4], r6[3], r6[2], r6[1], r6[0]; lane 1 = b6[1], b6[0], g6[5], g6[4], g6[3], g6[2], g6[1]; lane 2 = DE, VSYNC, HSYNC, b6[5], b6[4], b6[3], b6[2]. Mode 1 (24-bit, top grouping) uses the six top colour bits in these lanes and drives lane 3 = 0, B1, B0, G1, G0, R1, R0.
- R5: Mode 2 (24-bit, low grouping) uses r6=red[5:0], g6=green[5:0] and b6=blue[5:0] in lanes 0..2 and drives lane 3 = 0, B7, B6, G7, G6, R7, R6.
- R6: The control slots carry the sync and enable inputs as placed in R4. Lane 3 slot 0 is always 0 in the 24-bit modes.
- R7: With mirror high at load, every data lane sends the loaded word's slot 6 first and slot 0 last.
- R8: The clock lane sends 1,1,0,0,0,1,1 over slots 0..6 in every mode, regardless of mirror.
- R9: Changes to the pixel, mode or mirror inputs between loads do not affect the word being sent.
- R10: While reset is held and after its release, all data lanes are 0, the counter is at slot 0 and the clock lane shows its slot 0 value (1).
- R11: Mode 3 behaves exactly as mode 0.
- R12: On cycles with `ser_en_i` low, the counter and all lane outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_en_i | input | 1 | Slot tick enable (seven per pixel) |
| red_i | input | 8 | Red component |
| green_i | input | 8 | Green component |
| blue_i | input | 8 | Blue component |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| de_i | input | 1 | Data enable |
| mode_i | input | 2 | Mapping: 0 18-bit, 1 24-bit top grouping, 2 24-bit low grouping, 3 as 0 |
| mirror_i | input | 1 | Reverse slot order on data lanes |
| pix_take_o | output | 1 | Pixel inputs sampled on this edge |
| lane_o | output | 4 | Data lane bits, current slot |
| clk_lane_o | output | 1 | Clock lane bit, current slot |

## Verification
Single-bit walking patterns on each colour input in both 24-bit modes pin every colour bit to one lane and slot, so any swapped or shifted slot shows up. Mixed patterns with both low colour bits set separate the 18-bit mode from the low grouping and show the ignored bits have no effect. Sync and enable combinations separate the three control slots from one another. Mirrored runs, inputs scrambled between loads, and tick gaps inside a pixel separate correct slot order, load-time sampling and hold behaviour from a serializer that follows its inputs live.

// File: rtl/lser_pkg.sv
package lser_pkg;
  localparam int SLOT_N  = 7;
  localparam int LANE_N  = 4;
  localparam int COLOR_W = 8;
  localparam int CNT_W   = $clog2(SLOT_N);

  typedef enum logic [1:0] {
    MAP_18     = 2'd0,
    MAP_24_MSB = 2'd1,
    MAP_24_LSB = 2'd2,
    MAP_RSVD   = 2'd3
  } map_mode_e;

  typedef struct packed {
    logic [COLOR_W-1:0] r;
    logic [COLOR_W-1:0] g;
    logic [COLOR_W-1:0] b;
    logic               hs;
    logic               vs;
    logic               de;
  } pixel_t;

  typedef logic [SLOT_N-1:0] slot_word_t;
endpackage

// File: rtl/lser_slot_ctr.sv
module lser_slot_ctr
  import lser_pkg::*;
#(
  parameter logic [SLOT_N-1:0] CLK_PAT = 7'b1100011
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] slot_o,
  output logic             load_o,
  output logic             clk_lane_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_N - 1);

  logic [CNT_W-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             slot_q <= '0;
    else if (tick_i) begin
      if (slot_q == LAST)    slot_q <= '0;
      else                   slot_q <= slot_q + CNT_W'(1);
    end
  end

  assign load_o     = tick_i && (slot_q == LAST);
  assign clk_lane_o = CLK_PAT[slot_q];
  assign slot_o     = slot_q;
endmodule

// File: rtl/lser_map.sv
module lser_map
  import lser_pkg::*;
(
  input  pixel_t                      pix_i,
  input  logic [1:0]                  mode_i,
  input  logic                        mirror_i,
  output logic [LANE_N-1:0][SLOT_N-1:0] words_o
);
  logic [5:0] r6, g6, b6;
  logic [LANE_N-1:0][SLOT_N-1:0] nat;

  // bit index of each word = slot number
  always_comb begin
    if (map_mode_e'(mode_i) == MAP_24_LSB) begin
      r6 = pix_i.r[5:0];
      g6 = pix_i.g[5:0];
      b6 = pix_i.b[5:0];
    end else begin
      r6 = pix_i.r[7:2];
      g6 = pix_i.g[7:2];
      b6 = pix_i.b[7:2];
    end
    nat[0] = {r6[0], r6[1], r6[2], r6[3], r6[4], r6[5], g6[0]};
    nat[1] = {g6[1], g6[2], g6[3], g6[4], g6[5], b6[0], b6[1]};
    nat[2] = {b6[2], b6[3], b6[4], b6[5], pix_i.hs, pix_i.vs, pix_i.de};
    unique case (map_mode_e'(mode_i))
      MAP_24_MSB: nat[3] = {pix_i.r[0], pix_i.r[1], pix_i.g[0], pix_i.g[1],
                            pix_i.b[0], pix_i.b[1], 1'b0};
      MAP_24_LSB: nat[3] = {pix_i.r[6], pix_i.r[7], pix_i.g[6], pix_i.g[7],
                            pix_i.b[6], pix_i.b[7], 1'b0};
      default:    nat[3] = '0;
    endcase
  end

  for (genvar l = 0; l < LANE_N; l++) begin : g_lane
    for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
      assign words_o[l][s] = mirror_i ? nat[l][SLOT_N-1-s] : nat[l][s];
    end
  end
endmodule

// File: rtl/lser_lane_reg.sv
module lser_lane_reg
  import lser_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  slot_word_t       word_i,
  input  logic [CNT_W-1:0] slot_i,
  output logic             bit_o
);
  slot_word_t word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (load_i) word_q <= word_i;
  end

  assign bit_o = word_q[slot_i];
endmodule

// File: rtl/rgb_lane_ser.sv
module rgb_lane_ser
  import lser_pkg::*;
#(
  parameter logic [SLOT_N-1:0] CLK_PATTERN = 7'b1100011
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ser_en_i,
  input  logic [COLOR_W-1:0] red_i,
  input  logic [COLOR_W-1:0] green_i,
  input  logic [COLOR_W-1:0] blue_i,
  input  logic               hsync_i,
  input  logic               vsync_i,
  input  logic               de_i,
  input  logic [1:0]         mode_i,
  input  logic               mirror_i,
  output logic               pix_take_o,
  output logic [LANE_N-1:0]  lane_o,
  output logic               clk_lane_o
);
  logic [CNT_W-1:0]              slot_q;
  logic                          load;
  pixel_t                        pix;
  logic [LANE_N-1:0][SLOT_N-1:0] words;

  assign pix = '{r: red_i, g: green_i, b: blue_i,
                 hs: hsync_i, vs: vsync_i, de: de_i};

  lser_slot_ctr #(.CLK_PAT(CLK_PATTERN)) i_slot_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (ser_en_i),
    .slot_o     (slot_q),
    .load_o     (load),
    .clk_lane_o (clk_lane_o)
  );

  lser_map i_map (
    .pix_i    (pix),
    .mode_i   (mode_i),
    .mirror_i (mirror_i),
    .words_o  (words)
  );

  for (genvar l = 0; l < LANE_N; l++) begin : g_lane
    lser_lane_reg i_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .word_i (words[l]),
      .slot_i (slot_q),
      .bit_o  (lane_o[l])
    );
  end

  assign pix_take_o = load;
endmodule

// File: rtl/lser_chk.sv
module lser_chk
  import lser_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ser_en_i,
  input logic [1:0]        mode_i,
  input logic              mirror_i,
  input logic              pix_take_o,
  input logic [LANE_N-1:0] lane_o,
  input logic              clk_lane_o,
  input logic [CNT_W-1:0]  slot_q
);
  logic [1:0] mode_seen_q;
  logic       mirror_seen_q;
  logic       wide_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_seen_q   <= 2'd0;
      mirror_seen_q <= 1'b0;
    end else if (pix_take_o) begin
      mode_seen_q   <= mode_i;
      mirror_seen_q <= mirror_i;
    end
  end

  assign wide_mode = (mode_seen_q == MAP_24_MSB) || (mode_seen_q == MAP_24_LSB);

  p_slot_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q < CNT_W'(SLOT_N));

  p_take_spacing_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_take_o |=> !pix_take_o);

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_en_i |=> ($stable(lane_o) && $stable(clk_lane_o)));

  p_clk_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_en_i && slot_q == CNT_W'(1)) |=> $fell(clk_lane_o));

  p_clk_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_en_i && slot_q == CNT_W'(4)) |=> $rose(clk_lane_o));

  p_lane3_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_mode |-> !lane_o[3]);

  p_ctl3_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_mode && slot_q == (mirror_seen_q ? CNT_W'(SLOT_N-1) : CNT_W'(0)))
      |-> !lane_o[3]);
endmodule

bind rgb_lane_ser lser_chk i_lser_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ser_en_i   (ser_en_i),
  .mode_i     (mode_i),
  .mirror_i   (mirror_i),
  .pix_take_o (pix_take_o),
  .lane_o     (lane_o),
  .clk_lane_o (clk_lane_o),
  .slot_q     (slot_q)
);

// File: tb/test_rgb_lane_ser.sv
module test_rgb_lane_ser;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ser_en;
  logic [7:0] r, g, b;
  logic       hs, vs, de;
  logic [1:0] mode;
  logic       mirror;
  logic       pix_take;
  logic [3:0] lane;
  logic       clk_lane;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  localparam logic [6:0] CLK_EXP = 7'b1100011;

  always #10ns clk = ~clk;

  rgb_lane_ser i_rgb_lane_ser (
    .clk_i(clk), .rst_ni(rst_n), .ser_en_i(ser_en),
    .red_i(r), .green_i(g), .blue_i(b),
    .hsync_i(hs), .vsync_i(vs), .de_i(de),
    .mode_i(mode), .mirror_i(mirror),
    .pix_take_o(pix_take), .lane_o(lane), .clk_lane_o(clk_lane)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // expected bit from the mapping tables in the requirements
  function automatic logic exp_bit(input int ln, input int sl,
                                   input logic [7:0] rv, gv, bv,
                                   input logic hv, vv, dv,
                                   input logic [1:0] m, input logic mir);
    int p;
    logic [5:0] r6, g6, b6;
    p = mir ? 6 - sl : sl;
    if (m == 2'd2) begin r6 = rv[5:0]; g6 = gv[5:0]; b6 = bv[5:0]; end
    else           begin r6 = rv[7:2]; g6 = gv[7:2]; b6 = bv[7:2]; end
    case (ln)
      0: return (p == 0) ? g6[0] : r6[6-p];
      1: return (p == 0) ? b6[1] : (p == 1) ? b6[0] : g6[7-p];
      2: case (p)
           0: return dv;
           1: return vv;
           2: return hv;
           default: return b6[8-p];
         endcase
      default: begin
        if (m == 2'd1) case (p)
          1: return bv[1]; 2: return bv[0]; 3: return gv[1];
          4: return gv[0]; 5: return rv[1]; 6: return rv[0];
          default: return 1'b0;
        endcase
        if (m == 2'd2) case (p)
          1: return bv[7]; 2: return bv[6]; 3: return gv[7];
          4: return gv[6]; 5: return rv[7]; 6: return rv[6];
          default: return 1'b0;
        endcase
        return 1'b0;
      end
    endcase
  endfunction

  task automatic send_pixel(input logic [7:0] rv, gv, bv, input logic hv, vv, dv,
                            input logic [1:0] m, input logic mir,
                            input int gap_slot, input bit scramble, input string req);
    logic [3:0] exp_l;
    r = rv; g = gv; b = bv; hs = hv; vs = vv; de = dv; mode = m; mirror = mir;
    ser_en = 1'b1;
    while (!pix_take) @(negedge clk);
    for (int s = 0; s < 7; s++) begin
      @(negedge clk);
      for (int l = 0; l < 4; l++) exp_l[l] = exp_bit(l, s, rv, gv, bv, hv, vv, dv, m, mir);
      chk(lane == exp_l, req, lane, exp_l);
      chk(clk_lane == CLK_EXP[s], "R8 clock lane", clk_lane, CLK_EXP[s]);
      chk(pix_take == (s == 6), "R1 take pulse", pix_take, s == 6);
      if (scramble && s == 0) begin  // R9
        r = ~rv; g = ~gv; b = ~bv; hs = ~hv; vs = ~vv; de = ~dv;
        mode = m ^ 2'b11; mirror = ~mir;
      end
      if (s == gap_slot) begin       // R12
        ser_en = 1'b0;
        repeat (3) begin
          @(negedge clk);
          chk(lane == exp_l, "R12 hold lanes", lane, exp_l);
          chk(clk_lane == CLK_EXP[s], "R12 hold clock", clk_lane, CLK_EXP[s]);
          chk(!pix_take, "R12 no take", pix_take, 0);
        end
        ser_en = 1'b1;
      end
    end
  endtask

  task automatic test_reset;  // R10, R2
    rst_n = 1'b0; ser_en = 1'b0; mode = 2'd1; mirror = 1'b0;
    r = 8'hFF; g = 8'hFF; b = 8'hFF; hs = 1'b1; vs = 1'b1; de = 1'b1;
    repeat (3) @(negedge clk);
    chk(lane == 4'h0, "R10 lanes in reset", lane, 0);
    chk(clk_lane == 1'b1, "R10 clock in reset", clk_lane, 1);
    rst_n = 1'b1;
    @(negedge clk);
    ser_en = 1'b1;
    for (int s = 0; s < 7; s++) begin
      if (s > 0) @(negedge clk);
      chk(lane == 4'h0, "R10 lanes after reset", lane, 0);
      chk(clk_lane == CLK_EXP[s], "R10 clock from slot 0", clk_lane, CLK_EXP[s]);
    end
  endtask

  task automatic test_map18;  // R3, R4
    send_pixel(8'hA7, 8'h5B, 8'hE6, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, -1, 0, "R3 map18");
    send_pixel(8'h03, 8'h03, 8'h03, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, -1, 0, "R3 low bits ignored");
    send_pixel(8'h96, 8'h3C, 8'h69, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, -1, 0, "R4 common lanes");
  endtask

  task automatic test_walk;  // R4, R5
    for (int i = 0; i < 24; i++) begin
      logic [23:0] v;
      v = 24'h1 << i;
      send_pixel(v[23:16], v[15:8], v[7:0], 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, -1, 0, "R4 walk");
      send_pixel(v[23:16], v[15:8], v[7:0], 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, -1, 0, "R5 walk");
    end
  endtask

  task automatic test_ctl;  // R6
    for (int c = 0; c < 8; c++)
      send_pixel(8'h00, 8'h00, 8'h00, c[0], c[1], c[2], 2'd1, 1'b0, -1, 0, "R6 control");
    send_pixel(8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, -1, 0, "R6 ctl3 zero");
  endtask

  task automatic test_mirror;  // R7, R8
    for (int m = 0; m < 3; m++) begin
      send_pixel(8'hC5, 8'h3A, 8'h9E, 1'b1, 1'b0, 1'b1, 2'(m), 1'b1, -1, 0, "R7 mirror");
      send_pixel(8'h81, 8'h42, 8'h24, 1'b0, 1'b1, 1'b1, 2'(m), 1'b1, -1, 0, "R7 mirror");
    end
  endtask

  task automatic test_reserved;  // R11
    send_pixel(8'hB3, 8'h6D, 8'hF1, 1'b1, 1'b1, 1'b0, 2'd3, 1'b0, -1, 0, "R11 mode3");
    send_pixel(8'hB3, 8'h6D, 8'hF1, 1'b1, 1'b1, 1'b0, 2'd3, 1'b1, -1, 0, "R11 mode3 mirror");
  endtask

  task automatic test_midchange;  // R9
    send_pixel(8'h5A, 8'hC3, 8'h0F, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, -1, 1, "R9 mid change");
    send_pixel(8'hE1, 8'h1E, 8'h77, 1'b0, 1'b1, 1'b1, 2'd2, 1'b1, -1, 1, "R9 mid change");
  endtask

  task automatic test_hold;  // R12, R2
    send_pixel(8'h6B, 8'hD4, 8'h39, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0, 3, 0, "R2 slots after gap");
    send_pixel(8'h6B, 8'hD4, 8'h39, 1'b1, 1'b0, 1'b1, 2'd1, 1'b1, 6, 0, "R2 slots after gap");
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    test_reset();
    test_map18();
    test_walk();
    test_ctl();
    test_mirror();
    test_reserved();
    test_midchange();
    test_hold();
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      report();
      $finish;
    end
  end
endmodule